// File: doc/BRIEF.md
# Tick-Driven Countdown Watchdog with Reset Pulse

This block is an 8-bit countdown watchdog that sits behind a simple register write port. A control register chooses how the counter is clocked: either from an external one-second tick or from one of three faster ticks built inside the block by dividing the system clock. The same register decides whether expiry drives the active-low reset output. Software arms the watchdog by writing a nonzero timeout to the value register. It keeps the watchdog alive by writing that value again before the count runs out, and it stops the watchdog by writing zero.

The counter value is visible at all times on an output, so firmware that starts after a reset can tell whether an earlier boot stage left the watchdog running. A strobe input marks each read of a separate status register elsewhere in the register file. Such a read clears the count as a side effect, which stops the watchdog. When the count steps from one to zero and reset routing is on, the reset output goes low for a fixed number of system clocks and then releases. The counter stays at zero until software loads it again.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, `count_o` is 0, `ctrl_o` is 0 and `wdt_rst_n` is 1.
- R2: A write with `reg_addr` = 0x10 stores `reg_wdata` into the control register, shown on `ctrl_o`. A write to any other address except 0x11 changes neither `ctrl_o` nor `count_o`.
- R3: A write with `reg_addr` = 0x11 and nonzero data loads that value into the counter on the next clock edge. This holds whether the counter was stopped or running, so a new write restarts the countdown.
- R4: Writing 0 to address 0x11 stops the watchdog. The count is 0, later ticks leave it at 0, and no reset pulse follows.
- R5: While the count is nonzero, each selected tick lowers it by exactly one. Cycles with no selected tick leave it unchanged.
- R6: Control bits 1:0 select the tick. Code 2'b10 selects the `tick_1hz` input. Codes 2'b00, 2'b01 and 2'b11 select internal ticks that occur once every DIV_A, DIV_B and DIV_C system clocks respectively.
- R7: When a tick takes the count from 1 to 0 and control bits 7:6 are 2'b11, `wdt_rst_n` goes low from the next cycle for exactly RST_CYCLES clocks, then returns high. The count holds at 0 throughout.
- R8: When control bits 7:6 are anything other than 2'b11, expiry does not lower `wdt_rst_n`.
- R9: A cycle with `status_rd` high forces the count to 0, which stops the watchdog. `status_rd` takes priority over a value write in the same cycle.
- R10: A value write in the same cycle as a selected tick loads the written value, and the tick is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| status_rd | input | 1 | Pulses high for each read of the side-effect status register |
| tick_1hz | input | 1 | One-cycle pulse per second from the slow time base |
| ctrl_o | output | 8 | Current control register contents |
| count_o | output | 8 | Current watchdog count (0 means stopped) |
| wdt_rst_n | output | 1 | Active-low reset issued on expiry |

## Verification
The bench sweeps timeouts from 1 to 12 and also 255. For each timeout it counts down tick by tick and measures the reset pulse to the exact cycle. A counter that skipped or repeated a step, fired one tick early, or produced a pulse of the wrong length would therefore show up. Each internal tick rate is measured as the number of clocks between two decrements, which catches an off-by-one in a divider or a swapped select code. Collisions of a status read or a tick with a value write are driven in the same cycle, which exposes a wrong priority order. Expiry is also run with every mode code other than reset routing, which exposes a pulse that ignores the mode bits.

// File: rtl/tick_watchdog_pkg.sv
package tick_watchdog_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 8;
    localparam int CNT_W  = 8;

    localparam logic [REG_AW-1:0] ADDR_CTRL  = 8'h10;
    localparam logic [REG_AW-1:0] ADDR_VALUE = 8'h11;

    localparam logic [1:0] MODE_RESET = 2'b11;
    localparam logic [1:0] SEL_SLOW   = 2'b10;

    typedef struct packed {
        logic [1:0] mode;
        logic [3:0] spare;
        logic [1:0] sel;
    } ctrl_t;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/twd_prescale.sv
module twd_prescale
    import tick_watchdog_pkg::*;
#(
    parameter int unsigned DIV_A = 256,
    parameter int unsigned DIV_B = 1024,
    parameter int unsigned DIV_C = 16384
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       tick_slow,
    output logic       tick_o
);
    localparam int unsigned NDIV   = 3;
    localparam int unsigned MAXDIV = max3(DIV_A, DIV_B, DIV_C);
    localparam int unsigned CW     = $clog2(MAXDIV + 1);
    localparam int unsigned DIVS [NDIV] = '{DIV_A, DIV_B, DIV_C};

    logic [NDIV-1:0] fast_tick;

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        localparam logic [CW-1:0] LAST = CW'(DIVS[g] - 1);

        typedef struct packed {
            logic [CW-1:0] cnt;
        } div_t;

        div_t div_d, div_q;

        always_comb begin
            div_d = div_q;
            if (div_q.cnt >= LAST) begin
                div_d.cnt = '0;
            end else begin
                div_d.cnt = div_q.cnt + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                div_q <= '0;
            end else begin
                div_q <= div_d;
            end
        end

        assign fast_tick[g] = (div_q.cnt >= LAST);
    end

    always_comb begin
        unique case (sel)
            2'b00:    tick_o = fast_tick[0];
            2'b01:    tick_o = fast_tick[1];
            SEL_SLOW: tick_o = tick_slow;
            default:  tick_o = fast_tick[2];
        endcase
    end

endmodule

// File: rtl/twd_counter.sv
module twd_counter
    import tick_watchdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       expire_d;

    always_comb begin
        st_d     = st_q;
        expire_d = 1'b0;
        if (clear) begin
            st_d.count = '0;
        end else if (load) begin
            st_d.count = load_val;
        end else if (tick && (st_q.count != '0)) begin
            st_d.count = st_q.count - 1'b1;
            expire_d   = (st_q.count == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.count;
    assign expire_o = expire_d;

endmodule

// File: rtl/twd_pulse.sv
module twd_pulse #(
    parameter int unsigned RST_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic rst_n_o
);
    localparam int unsigned PW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } pulse_state_t;

    pulse_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.left = PW'(RST_CYCLES);
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_n_o = (st_q.left == '0);

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import tick_watchdog_pkg::*;
#(
    parameter int unsigned DIV_A      = 256,
    parameter int unsigned DIV_B      = 1024,
    parameter int unsigned DIV_C      = 16384,
    parameter int unsigned RST_CYCLES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              status_rd,
    input  logic              tick_1hz,
    output logic [REG_DW-1:0] ctrl_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              wdt_rst_n
);
    typedef struct packed {
        ctrl_t ctrl;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       wr_ctrl, wr_value;
    logic       sel_tick, expire;

    assign wr_ctrl  = reg_we && (reg_addr == ADDR_CTRL);
    assign wr_value = reg_we && (reg_addr == ADDR_VALUE);

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl = ctrl_t'(reg_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    twd_prescale #(
        .DIV_A (DIV_A),
        .DIV_B (DIV_B),
        .DIV_C (DIV_C)
    ) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (st_q.ctrl.sel),
        .tick_slow (tick_1hz),
        .tick_o    (sel_tick)
    );

    twd_counter u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (status_rd),
        .load     (wr_value),
        .load_val (reg_wdata),
        .tick     (sel_tick),
        .count_o  (count_o),
        .expire_o (expire)
    );

    twd_pulse #(
        .RST_CYCLES (RST_CYCLES)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (expire && (st_q.ctrl.mode == MODE_RESET)),
        .rst_n_o (wdt_rst_n)
    );

    assign ctrl_o = st_q.ctrl;

endmodule

// File: rtl/tick_watchdog_chk.sv
module tick_watchdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic       status_rd,
    input logic [7:0] ctrl_o,
    input logic [7:0] count_o,
    input logic       wdt_rst_n
);
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |=> (count_o == 8'd0)); // R9

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && !status_rd) |=> ((count_o == $past(count_o)) || (count_o == $past(count_o) - 8'd1))); // R5

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_o == 8'd0) && !reg_we) |=> (count_o == 8'd0)); // R4

    AST_PULSE_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst_n) |-> ((count_o == 8'd0) && ($past(count_o) == 8'd1))); // R7

    AST_PULSE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_o[7:6] != 2'b11) && wdt_rst_n) |=> wdt_rst_n); // R8

endmodule

bind tick_watchdog tick_watchdog_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .status_rd (status_rd),
    .ctrl_o    (ctrl_o),
    .count_o   (count_o),
    .wdt_rst_n (wdt_rst_n)
);

// File: tb/tick_watchdog_tb_top.sv
module tick_watchdog_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_A = 3;
    localparam int DIV_B = 5;
    localparam int DIV_C = 7;
    localparam int RSTC  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       status_rd = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [7:0] ctrl_o;
    logic [7:0] count_o;
    logic       wdt_rst_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_watchdog #(
        .DIV_A (DIV_A), .DIV_B (DIV_B), .DIV_C (DIV_C), .RST_CYCLES (RSTC)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .status_rd (status_rd), .tick_1hz (tick_1hz),
        .ctrl_o (ctrl_o), .count_o (count_o), .wdt_rst_n (wdt_rst_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic tick1();
        tick_1hz = 1'b1;
        step();
        tick_1hz = 1'b0;
    endtask

    task automatic measure_pulse(input string req);
        int n;
        n = 0;
        while (!wdt_rst_n && n < 100) begin
            n++;
            chk(count_o == 0, req, count_o, 0);
            step();
        end
        chk(n == RSTC, req, n, RSTC);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] start_v;
        step(); step();
        // R1 reset values
        chk(count_o == 0, "R1", count_o, 0);
        chk(ctrl_o == 0, "R1", ctrl_o, 0);
        chk(wdt_rst_n == 1, "R1", wdt_rst_n, 1);
        rst_n = 1'b1;
        step();

        // R2 control write and foreign address
        wr(8'h10, 8'hC2);
        chk(ctrl_o == 8'hC2, "R2", ctrl_o, 8'hC2);
        wr(8'h12, 8'hFF);
        chk(ctrl_o == 8'hC2, "R2", ctrl_o, 8'hC2);
        chk(count_o == 0, "R2", count_o, 0);

        // R3 R5 R7 sweep of timeouts with reset routing on
        for (int v = 1; v <= 13; v++) begin
            automatic int tv = (v == 13) ? 255 : v;
            wr(8'h11, 8'(tv));
            chk(count_o == tv, "R3", count_o, tv);
            for (int k = 1; k <= tv; k++) begin
                step();
                chk(count_o == tv - k + 1, "R5", count_o, tv - k + 1);
                tick1();
                if (k < tv) begin
                    chk(count_o == tv - k, "R5", count_o, tv - k);
                    chk(wdt_rst_n == 1, "R7", wdt_rst_n, 1);
                end else begin
                    chk(count_o == 0, "R7", count_o, 0);
                    chk(wdt_rst_n == 0, "R7", wdt_rst_n, 0);
                    measure_pulse("R7");
                end
            end
            step();
            chk(count_o == 0 && wdt_rst_n, "R7", count_o, 0);
        end

        // R3 restart while running
        wr(8'h11, 8'd10);
        tick1(); tick1();
        chk(count_o == 8, "R5", count_o, 8);
        wr(8'h11, 8'd7);
        chk(count_o == 7, "R3", count_o, 7);
        tick1();
        chk(count_o == 6, "R3", count_o, 6);

        // R10 write beats a same-cycle tick
        tick_1hz = 1'b1; reg_we = 1'b1; reg_addr = 8'h11; reg_wdata = 8'd9;
        step();
        tick_1hz = 1'b0; reg_we = 1'b0;
        chk(count_o == 9, "R10", count_o, 9);

        // R9 status read clears; beats a same-cycle write
        status_rd = 1'b1; step(); status_rd = 1'b0;
        chk(count_o == 0, "R9", count_o, 0);
        tick1(); tick1();
        chk(count_o == 0, "R9", count_o, 0);
        chk(wdt_rst_n == 1, "R9", wdt_rst_n, 1);
        status_rd = 1'b1; reg_we = 1'b1; reg_addr = 8'h11; reg_wdata = 8'd5;
        step();
        status_rd = 1'b0; reg_we = 1'b0;
        chk(count_o == 0, "R9", count_o, 0);

        // R4 write of zero stops
        wr(8'h11, 8'd5);
        tick1();
        wr(8'h11, 8'd0);
        chk(count_o == 0, "R4", count_o, 0);
        for (int k = 0; k < 6; k++) begin
            tick1();
            chk(count_o == 0 && wdt_rst_n, "R4", count_o, 0);
        end

        // R8 other modes give no pulse
        for (int m = 0; m < 3; m++) begin
            wr(8'h10, {2'(m), 6'b000010});
            wr(8'h11, 8'd2);
            tick1(); tick1();
            chk(count_o == 0, "R8", count_o, 0);
            for (int k = 0; k < RSTC + 2; k++) begin
                chk(wdt_rst_n == 1, "R8", wdt_rst_n, 1);
                step();
            end
        end

        // R6 slow select: no decrement without the tick
        wr(8'h10, 8'h02);
        wr(8'h11, 8'd4);
        for (int k = 0; k < 40; k++) step();
        chk(count_o == 4, "R6", count_o, 4);

        // R6 internal tick rates
        for (int s = 0; s < 3; s++) begin
            automatic logic [1:0] code = (s == 0) ? 2'b00 : (s == 1) ? 2'b01 : 2'b11;
            automatic int exp_div = (s == 0) ? DIV_A : (s == 1) ? DIV_B : DIV_C;
            wr(8'h10, {6'b0, code});
            wr(8'h11, 8'd6);
            start_v = count_o;
            n = 0;
            while (count_o == start_v && n < 50) begin step(); n++; end
            start_v = count_o;
            n = 0;
            while (count_o == start_v && n < 50) begin step(); n++; end
            chk(n == exp_div, "R6", n, exp_div);
            n = 0;
            start_v = count_o;
            while (count_o == start_v && n < 50) begin step(); n++; end
            chk(n == exp_div, "R6", n, exp_div);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule